// File: doc/BRIEF.md
# Wake Pin Trigger Detector

This block watches a small group of external wake pins and raises one event flag per pin according to a trigger condition chosen by software. Each pin first passes through a two-stage synchronizer. Edges are then found by comparing the current synchronized sample with the sample one cycle older. The per-pin event flags feed the wake status logic that sits beside this block.

Software programs each pin through its own 32-bit register on a simple memory-mapped bus. Writes are single-cycle and reads are combinational. The register holds a 3-bit trigger code and a detector hold bit. Its bit 0 returns the pin's synchronized level, so software can read the live pin state from the same word that configures it. Out of reset every pin is disarmed (code 4), so nothing fires until software arms a pin.

Top module: `wake_trig_top`

## Requirements
- R1: The register of pin k sits at byte address BASE + 8·k (BASE = 0x330 by default). Bit 0 of a read returns that pin's level after two clock edges of synchronization.
- R2: After reset every pin register reads 0x00000008 (trigger code 4, hold bit clear) with bit 0 equal to the synchronized pin level, and every event output is low.
- R3: The trigger code is stored in bits [3:1] and the hold bit in bit 4, and both read back as written. Bit 0 ignores writes. Bits [31:5] ignore writes and read as zero.
- R4: With code 0 (level low), the event stays high for every cycle in which the synchronized pin is low.
- R5: With code 1 (level high), the event stays high for every cycle in which the synchronized pin is high.
- R6: With code 2 (falling edge), each high-to-low transition of the synchronized pin produces an event exactly one cycle long.
- R7: With code 3 (rising edge), each low-to-high transition of the synchronized pin produces an event exactly one cycle long.
- R8: With code 6 (either edge), every transition of the synchronized pin produces a one-cycle event.
- R9: Codes 4, 5 and 7 never produce an event.
- R10: While the hold bit (bit 4) of a pin is set, its event output stays low. An edge that happened during the hold does not fire after the hold is released.
- R11: A write to any address that is not a pin register changes nothing, and a read from such an address returns zero.
- R12: A pin transition that is set up before clock edge t shows as an edge event in the cycle that follows edge t+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data, zero when no pin register is addressed |
| wake_pin | input | NUM_PINS (8) | Asynchronous wake pin inputs |
| wake_evt | output | NUM_PINS (8) | Per-pin event flags to the status logic |

## Verification
The assertions assume the bus addresses are byte aligned and that BASE is a multiple of 8, so any address whose low three bits are non-zero can never reach a register. They also assume that single-edge events are judged against a trigger code that does not change in the cycle that follows. The stimulus keeps to these assumptions by drawing addresses either from the pin register set or from a short list of misaligned and out-of-range offsets. Configuration writes are random but spaced apart. Pin levels toggle at random with a bias toward holding, so that both the level modes and the edge modes see long runs as well as short ones.

// File: rtl/wake_trig_pkg.sv
package wake_trig_pkg;

    localparam int WAKE_MAX_PINS = 8;
    localparam int CFG_MODE_LSB  = 1;
    localparam int CFG_HOLD_BIT  = 4;

    localparam logic [2:0] TRIG_LVL_LO = 3'd0;
    localparam logic [2:0] TRIG_LVL_HI = 3'd1;
    localparam logic [2:0] TRIG_FALL   = 3'd2;
    localparam logic [2:0] TRIG_RISE   = 3'd3;
    localparam logic [2:0] TRIG_OFF    = 3'd4;
    localparam logic [2:0] TRIG_ANY    = 3'd6;

    typedef struct packed {
        logic       hold;
        logic [2:0] mode;
    } pin_cfg_t;

    localparam pin_cfg_t PIN_CFG_RESET = '{hold: 1'b0, mode: TRIG_OFF};

    function automatic logic trig_eval(input logic [2:0] mode,
                                       input logic       cur,
                                       input logic       prev);
        logic hit;
        case (mode)
            TRIG_LVL_LO: hit = ~cur;
            TRIG_LVL_HI: hit = cur;
            TRIG_FALL:   hit = prev & ~cur;
            TRIG_RISE:   hit = ~prev & cur;
            TRIG_ANY:    hit = prev ^ cur;
            default:     hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic [31:0] cfg_word(input pin_cfg_t c, input logic lvl);
        logic [31:0] w;
        w = '0;
        w[CFG_HOLD_BIT] = c.hold;
        w[CFG_MODE_LSB +: 3] = c.mode;
        w[0] = lvl;
        return w;
    endfunction

    function automatic pin_cfg_t cfg_from_word(input logic [31:0] w);
        pin_cfg_t c;
        c.hold = w[CFG_HOLD_BIT];
        c.mode = w[CFG_MODE_LSB +: 3];
        return c;
    endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/wake_cfg_regs.sv
module wake_cfg_regs
    import wake_trig_pkg::*;
#(
    parameter int N      = 8,
    parameter int ADDR_W = 12,
    parameter int BASE   = 'h330,
    parameter int STRIDE = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [N-1:0]            lvl,
    output pin_cfg_t [N-1:0]        cfg_q
);
    logic [N-1:0] sel;

    for (genvar k = 0; k < N; k++) begin : g_reg
        localparam logic [ADDR_W-1:0] PIN_ADDR = ADDR_W'(BASE + k * STRIDE);
        assign sel[k] = bus_sel && (bus_addr == PIN_ADDR);

        always_ff @(posedge clk) begin
            if (rst)                 cfg_q[k] <= PIN_CFG_RESET;
            else if (sel[k] && bus_wr) cfg_q[k] <= cfg_from_word(bus_wdata);
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < N; k++)
            if (sel[k]) bus_rdata = bus_rdata | cfg_word(cfg_q[k], lvl[k]);
    end
endmodule

// File: rtl/wake_detect.sv
module wake_detect
    import wake_trig_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cur,
    input  pin_cfg_t cfg,
    output logic     evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= cur;
    end

    assign evt = ~cfg.hold & trig_eval(cfg.mode, cur, prev_q);
endmodule

// File: rtl/wake_trig_top.sv
module wake_trig_top
    import wake_trig_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int ADDR_W      = 12,
    parameter int BASE        = 'h330,
    parameter int STRIDE      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] wake_pin,
    output logic [NUM_PINS-1:0] wake_evt
);
    localparam int MODE_FLAT_W = 3 * NUM_PINS;

    logic [NUM_PINS-1:0]    pin_sync;
    pin_cfg_t [NUM_PINS-1:0] cfg_q;
    logic [MODE_FLAT_W-1:0] cfg_mode_flat;
    logic [NUM_PINS-1:0]    cfg_hold;

    wake_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .din (wake_pin),
        .dout(pin_sync)
    );

    wake_cfg_regs #(.N(NUM_PINS), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .lvl      (pin_sync),
        .cfg_q    (cfg_q)
    );

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        wake_detect det_i (
            .clk(clk),
            .rst(rst),
            .cur(pin_sync[k]),
            .cfg(cfg_q[k]),
            .evt(wake_evt[k])
        );
        assign cfg_mode_flat[3*k +: 3] = cfg_q[k].mode;
        assign cfg_hold[k]             = cfg_q[k].hold;
    end
endmodule

// File: rtl/wake_trig_chk.sv
module wake_trig_chk #(
    parameter int N      = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [N-1:0]      wake_evt,
    input logic [3*N-1:0]    mode_flat,
    input logic [N-1:0]      hold
);
    a_r3_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[31:5] == '0);

    a_r11_misaligned_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr[2:0] != 3'd0) |-> bus_rdata == '0);

    for (genvar k = 0; k < N; k++) begin : g_chk
        a_r9_disarmed_quiet: assert property (@(posedge clk) disable iff (rst)
            (mode_flat[3*k +: 3] == 3'd4 || mode_flat[3*k +: 3] == 3'd5 ||
             mode_flat[3*k +: 3] == 3'd7) |-> !wake_evt[k]);

        a_r10_hold_quiet: assert property (@(posedge clk) disable iff (rst)
            hold[k] |-> !wake_evt[k]);

        a_r7_rise_single_cycle: assert property (@(posedge clk) disable iff (rst)
            (mode_flat[3*k +: 3] == 3'd3 && wake_evt[k]) |=>
            (mode_flat[3*k +: 3] != 3'd3 || !wake_evt[k]));

        a_r6_fall_single_cycle: assert property (@(posedge clk) disable iff (rst)
            (mode_flat[3*k +: 3] == 3'd2 && wake_evt[k]) |=>
            (mode_flat[3*k +: 3] != 3'd2 || !wake_evt[k]));
    end
endmodule

bind wake_trig_top wake_trig_chk #(.N(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .wake_evt (wake_evt),
    .mode_flat(cfg_mode_flat),
    .hold     (cfg_hold)
);

// File: tb/wake_trig_top_tb_top.sv
`timescale 1ns/1ps
module wake_trig_top_tb_top;
    localparam int N    = 8;
    localparam int AW   = 12;
    localparam int BASE = 'h330;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  wake_pin = '0;
    logic [N-1:0]  wake_evt;

    int nvec = 0;
    int nfail = 0;
    bit evt_chk_on = 1'b0;
    bit done = 1'b0;

    // reference model state
    logic [2:0]   m_mode [N];
    logic         m_hold [N];
    logic [N-1:0] m_s1, m_s2, m_prev;

    always #2.5 clk = ~clk;

    wake_trig_top dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wake_pin(wake_pin), .wake_evt(wake_evt)
    );

    function automatic int pin_of(input logic [AW-1:0] a);
        for (int k = 0; k < N; k++)
            if (a == AW'(BASE + 8 * k)) return k;
        return -1;
    endfunction

    function automatic logic exp_evt(input int k);
        logic c, p, e;
        c = m_s2[k];
        p = m_prev[k];
        case (m_mode[k])
            3'd0: e = !c;
            3'd1: e = c;
            3'd2: e = p && !c;
            3'd3: e = !p && c;
            3'd6: e = p != c;
            default: e = 1'b0;
        endcase
        return e && !m_hold[k];
    endfunction

    function automatic string req_of(input int k);
        if (m_hold[k]) return "R10";
        case (m_mode[k])
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [31:0] exp_word(input int k);
        if (k < 0) return 32'h0;
        return {27'h0, m_hold[k], m_mode[k], m_s2[k]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) begin
                m_mode[k] <= 3'd4;
                m_hold[k] <= 1'b0;
            end
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
        end else begin
            m_s1 <= wake_pin;
            m_s2 <= m_s1;
            m_prev <= m_s2;
            if (bus_sel && bus_wr && pin_of(bus_addr) >= 0) begin
                m_mode[pin_of(bus_addr)] <= bus_wdata[3:1];
                m_hold[pin_of(bus_addr)] <= bus_wdata[4];
            end
        end
    end

    // per-cycle event comparison against the model
    always @(negedge clk) begin
        if (evt_chk_on) begin
            for (int k = 0; k < N; k++) begin
                nvec++;
                if (wake_evt[k] !== exp_evt(k)) begin
                    nfail++;
                    $display("FAIL %s pin %0d mode %0d evt actual %b expected %b at %0t",
                             req_of(k), k, m_mode[k], wake_evt[k], exp_evt(k), $time);
                end
            end
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_check(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        nvec++;
        if (bus_rdata !== exp_word(pin_of(a))) begin
            nfail++;
            $display("FAIL %s read 0x%03h actual 0x%08h expected 0x%08h",
                     req, a, bus_rdata, exp_word(pin_of(a)));
        end
        bus_sel = 1'b0;
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string req);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        evt_chk_on = 1'b1;

        // R2: reset state of every pin register (code 4, bit 0 = level)
        for (int k = 0; k < N; k++) bus_check(AW'(BASE + 8 * k), "R2");

        // R1: level readback after two synchronizer edges
        @(negedge clk); wake_pin = 8'hA5;
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < N; k++) bus_check(AW'(BASE + 8 * k), "R1");

        // R3: all-ones write keeps only code and hold, bit 0 stays the level
        bus_write(AW'(BASE + 8), 32'hFFFF_FFFF);
        bus_check(AW'(BASE + 8), "R3");
        bus_write(AW'(BASE + 8), 32'h0000_0008);
        bus_check(AW'(BASE + 8), "R3");

        // R11: unmapped writes change nothing; unmapped reads return zero
        bus_write(AW'(BASE + 4), 32'h0000_0002);
        bus_write(AW'(BASE - 8), 32'h0000_0002);
        bus_write(AW'(BASE + 8 * N), 32'h0000_0002);
        bus_check(AW'(BASE + 4), "R11");
        bus_check(AW'(BASE - 8), "R11");
        bus_check(AW'(BASE + 8 * N), "R11");
        for (int k = 0; k < N; k++) bus_check(AW'(BASE + 8 * k), "R11");

        // R12 / R7: rising-edge latency on pin 2 (code 3)
        @(negedge clk); wake_pin = '0;
        bus_write(AW'(BASE + 16), 32'h0000_0006);
        repeat (3) @(negedge clk);
        wake_pin[2] = 1'b1;
        @(negedge clk); chk_bit(wake_evt[2], 1'b0, "R12");
        @(negedge clk); chk_bit(wake_evt[2], 1'b1, "R12");
        @(negedge clk); chk_bit(wake_evt[2], 1'b0, "R7");

        // R10: edge during hold does not fire after release
        bus_write(AW'(BASE + 16), 32'h0000_0016);
        @(negedge clk); wake_pin[2] = 1'b0;
        @(negedge clk); wake_pin[2] = 1'b1;
        repeat (4) @(negedge clk);
        chk_bit(wake_evt[2], 1'b0, "R10");
        bus_write(AW'(BASE + 16), 32'h0000_0006);
        repeat (3) @(negedge clk);
        chk_bit(wake_evt[2], 1'b0, "R10");

        // constrained random: pins toggle with bias, sparse config writes and reads
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0;
            for (int k = 0; k < N; k++)
                if ($urandom_range(3) == 0) wake_pin[k] = ~wake_pin[k];
            r = $urandom;
            if (r[4:0] == 5'd0) begin
                bus_sel = 1'b1; bus_wr = 1'b1;
                bus_addr = (r[7:5] == 3'd0) ? AW'(BASE + 8 * N + 4 * r[9:8])
                                            : AW'(BASE + 8 * r[12:10]);
                bus_wdata = $urandom;
                bus_wdata[4] = (r[15:13] == 3'd0);
            end else if (r[4:0] == 5'd1) begin
                bus_sel = 1'b1;
                bus_addr = (r[7:5] == 3'd0) ? AW'(BASE + 8 * r[12:10] + 4)
                                            : AW'(BASE + 8 * r[12:10]);
                #1;
                nvec++;
                if (bus_rdata !== exp_word(pin_of(bus_addr))) begin
                    nfail++;
                    $display("FAIL %s read 0x%03h actual 0x%08h expected 0x%08h",
                             (pin_of(bus_addr) < 0) ? "R11" : "R1", bus_addr,
                             bus_rdata, exp_word(pin_of(bus_addr)));
                end
            end
        end

        @(negedge clk);
        bus_sel = 1'b0;
        evt_chk_on = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule